// File: doc/BRIEF.md
# Receive Holding Register with Deferred Overrun Status

This block sits between a serial receiver's deserializer and the register interface that software reads. It owns a single byte of receive storage and a packed status word. Each received byte arrives as a one-cycle strobe, with flags for a framing error, a parity error and a break. When a byte arrives while an unread byte is still held, the held byte is kept. The overrun is then recorded out of sight, so software first sees the valid byte and its own error flags unchanged.

Reading the data register takes the valid byte. The overrun only becomes visible after that read. Status then shows the overrun, a break marker if the lost traffic was a break, and an occupied flag for a byte that must be discarded. Clearing the overrun takes two steps: a status read that shows it, followed by a data read. An overflow of the autobaud counter in a bus-slave baud search uses the same overrun path. It has no byte attached and carries its own marker bit. A two-bit bus-state field can be written, and the code 10 returns the slave to waiting for a break.

The holding logic is a five-state machine:
- **EMPTY**: nothing held.
- **FULL**: a valid byte is held.
- **HELD**: a valid byte is held and an overrun is pending but hidden.
- **SHOW**: the overrun is visible and a status read is awaited.
- **ACK**: the status has been read and a data read is awaited.

Transitions:
- EMPTY→FULL on a byte.
- EMPTY→SHOW on an autobaud overflow.
- FULL→EMPTY on a data read.
- FULL→FULL on a data read in the same cycle as a byte.
- FULL→HELD on a byte or overflow without a read.
- HELD→SHOW on a data read.
- SHOW→ACK on a status read.
- ACK→EMPTY on a data read.

Top module: `rxs_rx_status`

## Requirements
- R1: A synchronous active-high reset gives status 0x00, irq low, data register 0x00 and bus state 2'b10 (wait-for-break).
- R2: A byte strobe while nothing is held loads the byte into the data register on the next cycle. Status then shows RDA (bit 7), with PE (bit 6), FE (bit 4) and BRKD (bit 3) copied from that byte's flags. Bits 2 to 0 read zero.
- R3: A data read while a valid byte is held, with no new byte in that cycle, returns status to 0x00.
- R4: A byte strobe while a valid byte is held does not change the data register. OE (bit 5) stays clear and status keeps the held byte's RDA/PE/FE/BRKD, even across status reads.
- R5: A data read after a hidden overrun makes status show RDA=1 and OE=1. BRKD is set if any overrunning byte carried the break flag, and PE and FE read zero.
- R6: While OE is visible, a data read without a preceding status read has no effect, and bytes arriving are discarded. A status read followed by a data read clears status to 0x00.
- R7: An autobaud overflow with nothing held sets OE and ATB (bit 2) with RDA=0, giving 0x24. If a byte is held, the overflow is deferred in the same way as a byte overrun. It clears by a status read followed by a data read.
- R8: A bus-state write stores its 2-bit value on the next cycle. Writing 2'b10 selects wait-for-break.
- R9: The receive interrupt is high exactly when the status word is non-zero.
- R10: A data read and a byte strobe in the same cycle while a byte is held consume the old byte and load the new one, leaving status at RDA only.
- R11: The status word seen during a cycle with a status read and a byte arrival is the value from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_strobe | input | 1 | One-cycle pulse: a byte has been deserialized |
| rx_byte | input | DATA_W | Received byte |
| rx_ferr | input | 1 | Framing error flag for this byte |
| rx_perr | input | 1 | Parity error flag for this byte |
| rx_brk | input | 1 | Break flag for this byte |
| abo_event | input | 1 | Autobaud counter overflow pulse |
| rd_data | input | 1 | Data register read strobe |
| rd_status | input | 1 | Status register read strobe |
| lin_wr | input | 1 | Bus-state write strobe |
| lin_wdata | input | 2 | Bus-state write value |
| data_reg | output | DATA_W | Data register contents |
| status | output | 8 | Packed status word |
| rx_irq | output | 1 | Receive interrupt |
| lin_state | output | 2 | Current bus-state field |

## Verification
The bench builds the block with the default 8-bit data width. This makes it practical to push every byte value through the capture and read path, with the three error flags taken from the low bits of each value, so all eight flag combinations are covered many times. The overrun sequence is swept over all sixteen combinations of first-byte flags and the overrunning byte's break flag. The bus-state field is swept over all four codes. Autobaud overflows are injected both with nothing held and with a byte held.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_FULL,
        ST_HELD,
        ST_SHOW,
        ST_ACK
    } hold_st_e;

    typedef struct packed {
        logic rda;
        logic pe;
        logic oe;
        logic fe;
        logic brkd;
        logic atb;
    } rx_flags_t;

    localparam int STAT_W   = 8;
    localparam int POS_RDA  = 7;
    localparam int POS_PE   = 6;
    localparam int POS_OE   = 5;
    localparam int POS_FE   = 4;
    localparam int POS_BRKD = 3;
    localparam int POS_ATB  = 2;

    localparam int          LIN_W          = 2;
    localparam logic [1:0]  LIN_WAIT_BREAK = 2'b10;

endpackage

// File: rtl/rxs_hold_fsm.sv
module rxs_hold_fsm
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_ferr,
    input  logic              rx_perr,
    input  logic              rx_brk,
    input  logic              abo_event,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] data_q,
    output rx_flags_t         flags
);

    hold_st_e st_q, st_d;

    logic fe_q, pe_q, brk_q;
    logic pend_byte_q, pend_brk_q, pend_atb_q;
    logic slot_free;

    assign slot_free = (st_q == ST_EMPTY) || ((st_q == ST_FULL) && rd_data);

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY, ST_FULL: begin
                if (slot_free) begin
                    if (rx_strobe)      st_d = abo_event ? ST_HELD : ST_FULL;
                    else if (abo_event) st_d = ST_SHOW;
                    else                st_d = ST_EMPTY;
                end else if (rx_strobe || abo_event) begin
                    st_d = ST_HELD;
                end
            end
            ST_HELD: if (rd_data)   st_d = ST_SHOW;
            ST_SHOW: if (rd_status) st_d = ST_ACK;
            ST_ACK:  if (rd_data)   st_d = ST_EMPTY;
            default: st_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_EMPTY;
        else     st_q <= st_d;
    end

    // held byte and its flags, pending overrun record
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q      <= '0;
            fe_q        <= 1'b0;
            pe_q        <= 1'b0;
            brk_q       <= 1'b0;
            pend_byte_q <= 1'b0;
            pend_brk_q  <= 1'b0;
            pend_atb_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_EMPTY, ST_FULL: begin
                    if (slot_free) begin
                        pend_byte_q <= 1'b0;
                        pend_brk_q  <= 1'b0;
                        pend_atb_q  <= abo_event;
                        if (rx_strobe) begin
                            data_q <= rx_byte;
                            fe_q   <= rx_ferr;
                            pe_q   <= rx_perr;
                            brk_q  <= rx_brk;
                        end else begin
                            fe_q  <= 1'b0;
                            pe_q  <= 1'b0;
                            brk_q <= 1'b0;
                        end
                    end else begin
                        pend_byte_q <= rx_strobe;
                        pend_brk_q  <= rx_strobe && rx_brk;
                        pend_atb_q  <= abo_event;
                    end
                end
                ST_HELD: begin
                    pend_byte_q <= pend_byte_q || rx_strobe;
                    pend_brk_q  <= pend_brk_q || (rx_strobe && rx_brk);
                    pend_atb_q  <= pend_atb_q || abo_event;
                    if (rd_data) begin
                        fe_q  <= 1'b0;
                        pe_q  <= 1'b0;
                        brk_q <= 1'b0;
                    end
                end
                ST_SHOW: begin
                    pend_atb_q <= pend_atb_q || abo_event;
                end
                ST_ACK: begin
                    if (rd_data) begin
                        pend_byte_q <= 1'b0;
                        pend_brk_q  <= 1'b0;
                        pend_atb_q  <= 1'b0;
                    end else begin
                        pend_atb_q <= pend_atb_q || abo_event;
                    end
                end
                default: ;
            endcase
        end
    end

    // visible flags
    always_comb begin
        flags = '0;
        unique case (st_q)
            ST_EMPTY: ;
            ST_FULL, ST_HELD: begin
                flags.rda  = 1'b1;
                flags.fe   = fe_q;
                flags.pe   = pe_q;
                flags.brkd = brk_q;
            end
            ST_SHOW, ST_ACK: begin
                flags.rda  = pend_byte_q;
                flags.oe   = 1'b1;
                flags.brkd = pend_brk_q;
                flags.atb  = pend_atb_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rxs_lin_state.sv
module rxs_lin_state
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [LIN_W-1:0] wdata,
    output logic [LIN_W-1:0] state_q
);

    always_ff @(posedge clk) begin
        if (rst)     state_q <= LIN_WAIT_BREAK;
        else if (wr) state_q <= wdata;
    end

endmodule

// File: rtl/rxs_status_pack.sv
module rxs_status_pack
    import rxs_pkg::*;
(
    input  rx_flags_t         flags,
    output logic [STAT_W-1:0] word,
    output logic              any
);

    always_comb begin
        word           = '0;
        word[POS_RDA]  = flags.rda;
        word[POS_PE]   = flags.pe;
        word[POS_OE]   = flags.oe;
        word[POS_FE]   = flags.fe;
        word[POS_BRKD] = flags.brkd;
        word[POS_ATB]  = flags.atb;
        any            = |flags;
    end

endmodule

// File: rtl/rxs_rx_status.sv
module rxs_rx_status
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_ferr,
    input  logic              rx_perr,
    input  logic              rx_brk,
    input  logic              abo_event,
    input  logic              rd_data,
    input  logic              rd_status,
    input  logic              lin_wr,
    input  logic [1:0]        lin_wdata,
    output logic [DATA_W-1:0] data_reg,
    output logic [7:0]        status,
    output logic              rx_irq,
    output logic [1:0]        lin_state
);

    rx_flags_t flags;

    rxs_hold_fsm #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .rx_strobe (rx_strobe),
        .rx_byte   (rx_byte),
        .rx_ferr   (rx_ferr),
        .rx_perr   (rx_perr),
        .rx_brk    (rx_brk),
        .abo_event (abo_event),
        .rd_data   (rd_data),
        .rd_status (rd_status),
        .data_q    (data_reg),
        .flags     (flags)
    );

    rxs_status_pack u_pack (
        .flags (flags),
        .word  (status),
        .any   (rx_irq)
    );

    rxs_lin_state u_lin (
        .clk     (clk),
        .rst     (rst),
        .wr      (lin_wr),
        .wdata   (lin_wdata),
        .state_q (lin_state)
    );

endmodule

// File: rtl/rxs_rx_status_chk.sv
module rxs_rx_status_chk
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_strobe,
    input logic [DATA_W-1:0] rx_byte,
    input logic              abo_event,
    input logic              rd_data,
    input logic              lin_wr,
    input logic [1:0]        lin_wdata,
    input logic [DATA_W-1:0] data_reg,
    input logic [7:0]        status,
    input logic              rx_irq,
    input logic [1:0]        lin_state
);

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && !abo_event && status == 8'h00)
        |=> (data_reg == $past(rx_byte) && status[POS_RDA]));

    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && status[POS_RDA] && !rd_data) |=> $stable(data_reg));

    a_r5_oe_deferred: assert property (@(posedge clk) disable iff (rst)
        (status[POS_RDA] && !status[POS_OE] && !rd_data) |=> !status[POS_OE]);

    a_r6_clear_by_data_read: assert property (@(posedge clk) disable iff (rst)
        $fell(status[POS_OE]) |-> $past(rd_data));

    a_r7_autobaud: assert property (@(posedge clk) disable iff (rst)
        (abo_event && !rx_strobe && status == 8'h00)
        |=> (status[POS_OE] && status[POS_ATB] && !status[POS_RDA]));

    a_r8_lin_write: assert property (@(posedge clk) disable iff (rst)
        lin_wr |=> (lin_state == $past(lin_wdata)));

    a_r9_irq: assert property (@(posedge clk) disable iff (rst)
        rx_irq == (status != 8'h00));

endmodule

bind rxs_rx_status rxs_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_strobe (rx_strobe),
    .rx_byte   (rx_byte),
    .abo_event (abo_event),
    .rd_data   (rd_data),
    .lin_wr    (lin_wr),
    .lin_wdata (lin_wdata),
    .data_reg  (data_reg),
    .status    (status),
    .rx_irq    (rx_irq),
    .lin_state (lin_state)
);

// File: tb/rxs_rx_status_bench.sv
module rxs_rx_status_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_strobe, rx_ferr, rx_perr, rx_brk, abo_event;
    logic [7:0] rx_byte;
    logic       rd_data, rd_status, lin_wr;
    logic [1:0] lin_wdata;
    logic [7:0] data_reg, status;
    logic       rx_irq;
    logic [1:0] lin_state;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    rxs_rx_status u_rxs_rx_status (
        .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_brk(rx_brk),
        .abo_event(abo_event), .rd_data(rd_data), .rd_status(rd_status),
        .lin_wr(lin_wr), .lin_wdata(lin_wdata), .data_reg(data_reg),
        .status(status), .rx_irq(rx_irq), .lin_state(lin_state)
    );

    function automatic logic [7:0] sw(input logic rda, pe, oe, fe, brk, atb);
        return {rda, pe, oe, fe, brk, atb, 2'b00};
    endfunction

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        rx_strobe = 0; rx_byte = 8'h00; rx_ferr = 0; rx_perr = 0; rx_brk = 0;
        abo_event = 0; rd_data = 0; rd_status = 0; lin_wr = 0; lin_wdata = 2'b00;
    endtask

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, got, exp);
        end
    endtask

    task automatic load(input logic [7:0] b, input logic fe, pe, brk);
        rx_strobe = 1; rx_byte = b; rx_ferr = fe; rx_perr = pe; rx_brk = brk;
        tick; idle;
    endtask

    task automatic rdd; rd_data = 1; tick; idle; endtask
    task automatic rds; rd_status = 1; tick; idle; endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle;
        rst = 1;
        tick; tick;
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 irq", rx_irq, 0);
        chk("R1 data", data_reg, 8'h00);
        chk("R1 lin", lin_state, 2'b10);
        rst = 0;
        tick;

        // R2, R3, R9: every byte, flags from low bits
        for (int b = 0; b < 256; b++) begin
            logic [7:0] v;
            v = b[7:0];
            load(v, v[0], v[1], v[2]);
            chk("R2 data", data_reg, v);
            chk("R2 status", status, sw(1, v[1], 0, v[0], v[2], 0));
            chk("R9 irq high", rx_irq, 1);
            rdd;
            chk("R3 status", status, 8'h00);
            chk("R9 irq low", rx_irq, 0);
        end

        // R4, R5, R6: overrun over all flag combinations
        for (int k = 0; k < 16; k++) begin
            logic [3:0] f;
            logic [7:0] a;
            f = k[3:0];
            a = 8'hA0 | {4'h0, f};
            load(a, f[0], f[1], f[2]);
            load(~a, 1'b1, 1'b1, f[3]);
            chk("R4 data kept", data_reg, a);
            chk("R4 status", status, sw(1, f[1], 0, f[0], f[2], 0));
            rds;
            chk("R4 status after status read", status, sw(1, f[1], 0, f[0], f[2], 0));
            rdd;
            chk("R5 status", status, sw(1, 0, 1, 0, f[3], 0));
            chk("R5 data", data_reg, a);
            rdd;
            chk("R6 data read without status read", status, sw(1, 0, 1, 0, f[3], 0));
            rd_status = 1; rx_strobe = 1; rx_byte = 8'h55;
            tick; idle;
            chk("R6 byte in ACK ignored", status, sw(1, 0, 1, 0, f[3], 0));
            chk("R6 data unchanged", data_reg, a);
            rdd;
            chk("R6 cleared", status, 8'h00);
            chk("R9 irq after clear", rx_irq, 0);
        end

        // R10 simultaneous read and byte
        load(8'h11, 0, 0, 0);
        rd_data = 1; rx_strobe = 1; rx_byte = 8'h22;
        tick; idle;
        chk("R10 data", data_reg, 8'h22);
        chk("R10 status", status, 8'h80);

        // R11 status read with byte arrival sees pre-update value
        rd_status = 1; rx_strobe = 1; rx_byte = 8'h33; rx_brk = 1;
        #1;
        chk("R11 status same cycle", status, 8'h80);
        tick; idle;
        chk("R11 data kept", data_reg, 8'h22);
        chk("R11 status after", status, 8'h80);
        rdd;
        chk("R5 break from overrun", status, sw(1, 0, 1, 0, 1, 0));
        rds; rdd;
        chk("R6 cleared again", status, 8'h00);

        // R7 autobaud overflow, nothing held
        abo_event = 1; tick; idle;
        chk("R7 status", status, 8'h24);
        chk("R7 irq", rx_irq, 1);
        chk("R7 data untouched", data_reg, 8'h22);
        rdd;
        chk("R7 data read alone", status, 8'h24);
        rds; rdd;
        chk("R7 cleared", status, 8'h00);

        // R7 autobaud overflow while byte held
        load(8'h44, 0, 0, 0);
        abo_event = 1; tick; idle;
        chk("R7 deferred", status, 8'h80);
        rdd;
        chk("R7 shown after read", status, 8'h24);
        rds; rdd;
        chk("R7 cleared held", status, 8'h00);

        // R8 bus-state field
        for (int v = 0; v < 4; v++) begin
            lin_wr = 1; lin_wdata = v[1:0];
            tick; idle;
            chk("R8 lin", lin_state, v[1:0]);
        end
        lin_wr = 1; lin_wdata = 2'b10; tick; idle;
        chk("R8 wait-for-break", lin_state, 2'b10);
        chk("R8 status untouched", status, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule